// File: doc/BRIEF.md
# Streaming Marker Bounding-Box and Centre Finder

This block sits behind a colour segmentation and noise filter stage. It takes a one-bit mask stream in raster order, where a 1 marks a pixel that belongs to the marker. Two qualifiers come with the stream: a line-valid and a frame-valid. In a single pass, and with no frame storage, it tracks the column and row of every accepted pixel. It records the leftmost, rightmost, topmost and bottommost marker pixels of the frame.

When frame-valid drops, the block registers the four box edges and the midpoint of the box. It also raises a one-cycle strobe that a downstream controller can use to read them. If a frame holds no marker pixel, the strobe still fires, with the found flag low. The last good box and centre then stay on the outputs.

Top module: `marker_box_tracker`

## Requirements
- R1: A pixel is accepted only in a cycle where line_valid and frame_valid are both 1. The mask bit has no effect on the box in any other cycle.
- R2: The column of the first accepted pixel of a line is 0, and it grows by one for each further accepted pixel. A falling edge of line_valid inside a frame sends the column back to 0 and advances the row by one.
- R3: A rising edge of frame_valid restarts the row at 0 and discards the box of the previous frame. This also holds when a marker pixel is accepted in that same cycle, which becomes pixel (0,0) of the new frame.
- R4: x_lo and y_lo report the smallest column and the smallest row of all marker pixels in the frame.
- R5: x_hi and y_hi report the largest column and the largest row of all marker pixels in the frame.
- R6: ctr_x = floor((x_lo + x_hi) / 2) and ctr_y = floor((y_lo + y_hi) / 2). The sum is formed one bit wider, so that it never overflows.
- R7: box_valid is 1 for exactly one cycle, in the cycle after the first clock edge that samples frame_valid low after it was high. The box and centre outputs change only together with that strobe.
- R8: When a frame holds no marker pixel, marker_found is 0 during its strobe, and the corner and centre outputs keep their previous values. Otherwise marker_found is 1.
- R9: During and after reset, before any frame completes, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock, one pixel per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_bit | input | 1 | Segmented pixel, 1 = marker |
| line_valid | input | 1 | High while a line's pixels are on the stream |
| frame_valid | input | 1 | High for the duration of a frame |
| box_valid | output | 1 | One-cycle strobe after each frame |
| marker_found | output | 1 | Last frame contained at least one marker pixel |
| x_lo | output | XW (10) | Leftmost marker column |
| x_hi | output | XW (10) | Rightmost marker column |
| y_lo | output | YW (9) | Topmost marker row |
| y_hi | output | YW (9) | Bottommost marker row |
| ctr_x | output | XW (10) | Box centre column |
| ctr_y | output | YW (9) | Box centre row |

## Verification
Two functions can fall in the same cycle: the frame-start clear of the extent trackers and the update caused by a marker pixel. To provoke this, the bench raises frame_valid and line_valid together with a 1 on the mask. The frame's true box then has its top-left corner at (0,0), even though the previous frame's box was elsewhere. The result is judged against the box the bench computes from the mask it drove. A wrong result shows up either as a stale corner from the old frame or as a missing (0,0).

// File: rtl/box_track_pkg.sv
package box_track_pkg;

  // Flags describing the stream events seen in one cycle.
  typedef struct packed {
    logic frame_start;
    logic frame_end;
    logic line_end;
    logic pix_ok;
  } stream_ev_t;

  // True when a candidate coordinate extends the current extent.
  function automatic logic beats(input logic want_min,
                                 input logic [31:0] cand,
                                 input logic [31:0] base);
    return want_min ? (cand < base) : (cand > base);
  endfunction

  // Midpoint of two coordinates, summed wide so nothing is lost.
  function automatic logic [31:0] midpoint(input logic [31:0] a,
                                           input logic [31:0] b);
    logic [32:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    return sum[32:1];
  endfunction

endpackage

// File: rtl/frame_sync.sv
module frame_sync (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     line_valid,
  input  logic                     frame_valid,
  output box_track_pkg::stream_ev_t ev
);
  logic lv_q;
  logic fv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lv_q <= 1'b0;
      fv_q <= 1'b0;
    end else begin
      lv_q <= line_valid;
      fv_q <= frame_valid;
    end
  end

  always_comb begin
    ev.frame_start = frame_valid & ~fv_q;
    ev.frame_end   = ~frame_valid & fv_q;
    ev.line_end    = lv_q & ~line_valid & frame_valid & fv_q;
    ev.pix_ok      = line_valid & frame_valid;
  end

endmodule

// File: rtl/pos_counter.sv
module pos_counter #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          line_end,
  input  logic          pix_ok,
  output logic [XW-1:0] cur_x,
  output logic [YW-1:0] cur_y
);
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;

  // Position of the pixel in this cycle; a frame start restarts at the origin.
  assign cur_x = frame_start ? '0 : x_q;
  assign cur_y = frame_start ? '0 : y_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (frame_start) begin
      x_q <= pix_ok ? XW'(1) : '0;
      y_q <= '0;
    end else if (line_end) begin
      x_q <= '0;
      y_q <= y_q + YW'(1);
    end else if (pix_ok) begin
      x_q <= x_q + XW'(1);
    end
  end

  // R2: a line end returns the column to zero and steps the row
  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_end && !frame_start |=> (x_q == '0) && (y_q == $past(y_q) + YW'(1)));

  // R1: without a qualified pixel or event the column stays put
  assert_col_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ok && !frame_start && !line_end |=> $stable(x_q));

  // R3: a frame start leaves the row at zero
  assert_row_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (y_q == '0));

endmodule

// File: rtl/extent_tracker.sv
module extent_tracker #(
  parameter int W      = 10,
  parameter bit IS_MIN = 1'b1,
  parameter int LIMIT  = 639
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         hit,
  input  logic [W-1:0] coord,
  output logic [W-1:0] ext
);
  localparam logic [W-1:0] START = IS_MIN ? W'(LIMIT) : '0;

  logic [W-1:0] ext_q;
  logic [W-1:0] base;
  logic         take;
  logic [W-1:0] nxt;

  always_comb begin
    base = init ? START : ext_q;
    take = hit && box_track_pkg::beats(IS_MIN, 32'(coord), 32'(base));
    nxt  = take ? coord : base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            ext_q <= START;
    else if (init || hit)  ext_q <= nxt;
  end

  assign ext = ext_q;

  // R4 / R5: after a marker pixel the extent covers it
  assert_covers_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (IS_MIN ? (ext_q <= $past(coord)) : (ext_q >= $past(coord))));

  // R5: within a frame the extent only widens
  assert_only_widens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> (IS_MIN ? (ext_q <= $past(ext_q)) : (ext_q >= $past(ext_q))));

endmodule

// File: rtl/marker_box_tracker.sv
module marker_box_tracker #(
  parameter  int FRAME_W = 640,
  parameter  int FRAME_H = 480,
  localparam int XW      = $clog2(FRAME_W + 1),
  localparam int YW      = $clog2(FRAME_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_bit,
  input  logic          line_valid,
  input  logic          frame_valid,
  output logic          box_valid,
  output logic          marker_found,
  output logic [XW-1:0] x_lo,
  output logic [XW-1:0] x_hi,
  output logic [YW-1:0] y_lo,
  output logic [YW-1:0] y_hi,
  output logic [XW-1:0] ctr_x,
  output logic [YW-1:0] ctr_y
);
  box_track_pkg::stream_ev_t ev;
  logic [XW-1:0] cur_x;
  logic [YW-1:0] cur_y;
  logic          hit;
  logic          seen_q;
  logic [XW-1:0] x_ext [2];
  logic [YW-1:0] y_ext [2];

  frame_sync u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_valid  (line_valid),
    .frame_valid (frame_valid),
    .ev          (ev)
  );

  pos_counter #(.XW(XW), .YW(YW)) u_pos (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (ev.frame_start),
    .line_end    (ev.line_end),
    .pix_ok      (ev.pix_ok),
    .cur_x       (cur_x),
    .cur_y       (cur_y)
  );

  assign hit = ev.pix_ok & mask_bit;

  // Index 0 tracks the minimum, index 1 the maximum.
  for (genvar k = 0; k < 2; k++) begin : g_ext
    extent_tracker #(.W(XW), .IS_MIN(k == 0), .LIMIT(FRAME_W - 1)) u_x (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (ev.frame_start),
      .hit   (hit),
      .coord (cur_x),
      .ext   (x_ext[k])
    );
    extent_tracker #(.W(YW), .IS_MIN(k == 0), .LIMIT(FRAME_H - 1)) u_y (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (ev.frame_start),
      .hit   (hit),
      .coord (cur_y),
      .ext   (y_ext[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                seen_q <= 1'b0;
    else if (ev.frame_start)   seen_q <= hit;
    else if (hit)              seen_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      box_valid    <= 1'b0;
      marker_found <= 1'b0;
      x_lo         <= '0;
      x_hi         <= '0;
      y_lo         <= '0;
      y_hi         <= '0;
      ctr_x        <= '0;
      ctr_y        <= '0;
    end else begin
      box_valid <= ev.frame_end;
      if (ev.frame_end) begin
        marker_found <= seen_q;
        if (seen_q) begin
          x_lo  <= x_ext[0];
          x_hi  <= x_ext[1];
          y_lo  <= y_ext[0];
          y_hi  <= y_ext[1];
          ctr_x <= XW'(box_track_pkg::midpoint(32'(x_ext[0]), 32'(x_ext[1])));
          ctr_y <= YW'(box_track_pkg::midpoint(32'(y_ext[0]), 32'(y_ext[1])));
        end
      end
    end
  end

  // R7: the strobe lasts one cycle and follows the drop of frame_valid
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    box_valid |=> !box_valid);
  assert_strobe_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    box_valid |-> $past(ev.frame_end));
  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !box_valid |-> $stable(ctr_x) && $stable(ctr_y) && $stable(x_lo) && $stable(y_hi));

  // R6: centre lies inside the box, within half a pixel of the middle
  assert_centre_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    box_valid && marker_found |->
      (x_lo <= x_hi) && (y_lo <= y_hi) &&
      ((32'(x_lo) + 32'(x_hi) - 2 * 32'(ctr_x)) <= 32'd1) &&
      ((32'(y_lo) + 32'(y_hi) - 2 * 32'(ctr_y)) <= 32'd1));

  // R8: an empty frame keeps the previous result
  assert_empty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    box_valid && !marker_found |-> $stable(ctr_x) && $stable(ctr_y) &&
                                   $stable(x_hi) && $stable(y_lo));

endmodule

// File: tb/test_marker_box_tracker.sv
module test_marker_box_tracker;
  localparam int W  = 16;
  localparam int H  = 12;
  localparam int XW = $clog2(W + 1);
  localparam int YW = $clog2(H + 1);

  typedef struct {
    int found; int xl; int xh; int yl; int yh; int cx; int cy;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mask_bit = 1'b0;
  logic line_valid = 1'b0;
  logic frame_valid = 1'b0;
  logic box_valid, marker_found;
  logic [XW-1:0] x_lo, x_hi, ctr_x;
  logic [YW-1:0] y_lo, y_hi, ctr_y;

  always #4 clk = ~clk;

  marker_box_tracker #(.FRAME_W(W), .FRAME_H(H)) i_marker_box_tracker (
    .clk(clk), .rst_n(rst_n), .mask_bit(mask_bit), .line_valid(line_valid),
    .frame_valid(frame_valid), .box_valid(box_valid), .marker_found(marker_found),
    .x_lo(x_lo), .x_hi(x_hi), .y_lo(y_lo), .y_hi(y_hi), .ctr_x(ctr_x), .ctr_y(ctr_y)
  );

  int n_checks = 0;
  int n_fail = 0;
  int n_strobes = 0;
  int n_frames = 0;
  bit done = 0;
  bit prev_valid = 0;
  exp_t q[$];
  exp_t held = '{0, 0, 0, 0, 0, 0, 0};

  // marker shape of the current frame
  bit use_rect, use_pt, use_pt2;
  int rx0, ry0, rx1, ry1, px, py, px2, py2;

  function automatic bit is_mark(int x, int y);
    return (use_rect && x >= rx0 && x <= rx1 && y >= ry0 && y <= ry1) ||
           (use_pt && x == px && y == py) || (use_pt2 && x == px2 && y == py2);
  endfunction

  task automatic check(string req, string what, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Driver: computes the expected result, then plays the frame.
  task automatic run_frame(bit tight, bit junk);
    exp_t e;
    int xl = W, xh = -1, yl = H, yh = -1;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        if (is_mark(x, y)) begin
          if (x < xl) xl = x;
          if (x > xh) xh = x;
          if (y < yl) yl = y;
          if (y > yh) yh = y;
        end
    if (xh < 0) begin
      e = held; e.found = 0;
    end else begin
      e = '{1, xl, xh, yl, yh, (xl + xh) / 2, (yl + yh) / 2};
    end
    held = e;
    q.push_back(e);
    n_frames++;
    if (junk) begin // R1: mask and line_valid active with frame_valid low
      @(negedge clk); frame_valid = 0; line_valid = 1; mask_bit = 1;
      repeat (2) @(negedge clk);
      @(negedge clk); line_valid = 0; mask_bit = 0;
    end
    for (int y = 0; y < H; y++) begin
      if (!(tight && y == 0)) begin
        @(negedge clk); frame_valid = 1; line_valid = 0; mask_bit = junk;
        @(negedge clk); mask_bit = 0;
      end
      for (int x = 0; x < W; x++) begin
        @(negedge clk); frame_valid = 1; line_valid = 1; mask_bit = is_mark(x, y);
      end
      @(negedge clk); line_valid = 0; mask_bit = junk; // R1: blanking junk
    end
    @(negedge clk); mask_bit = 0; frame_valid = 0;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on each strobe, checks hold otherwise.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (box_valid) begin
        n_strobes++;
        if (prev_valid) check("R7", "strobe length", 2, 1);
        if (q.size() == 0) check("R7", "unexpected strobe", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check("R8", "marker_found", int'(marker_found), e.found);
          check("R4", "x_lo", int'(x_lo), e.xl);
          check("R4", "y_lo", int'(y_lo), e.yl);
          check("R5", "x_hi", int'(x_hi), e.xh);
          check("R5", "y_hi", int'(y_hi), e.yh);
          check("R6", "ctr_x", int'(ctr_x), e.cx);
          check("R6", "ctr_y", int'(ctr_y), e.cy);
        end
      end else if (n_strobes > 0 && q.size() > 0) begin
        // R7: outputs hold the last result while a frame streams
        if (int'(ctr_x) != held_prev.cx || int'(x_lo) != held_prev.xl ||
            int'(y_hi) != held_prev.yh)
          check("R7", "hold ctr_x", int'(ctr_x), held_prev.cx);
      end
      if (box_valid) held_prev = '{int'(marker_found), int'(x_lo), int'(x_hi),
                                   int'(y_lo), int'(y_hi), int'(ctr_x), int'(ctr_y)};
      prev_valid = box_valid;
    end
  end
  exp_t held_prev = '{0, 0, 0, 0, 0, 0, 0};

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "box_valid in reset", int'(box_valid), 0);
    check("R9", "ctr_x in reset", int'(ctr_x), 0);
    rst_n = 1;
    @(negedge clk);
    check("R9", "marker_found after reset", int'(marker_found), 0);
    check("R9", "x_hi after reset", int'(x_hi), 0);
    check("R9", "ctr_y after reset", int'(ctr_y), 0);

    // R8: empty first frame keeps zeros
    use_rect = 0; use_pt = 0; use_pt2 = 0;
    run_frame(0, 0);

    // R4 R5 R6: plain rectangle
    use_rect = 1; rx0 = 3; ry0 = 2; rx1 = 7; ry1 = 5;
    run_frame(0, 0);

    // R3: marker at (0,0) accepted in the frame-start cycle, plus far corner
    use_rect = 0; use_pt = 1; px = 0; py = 0; use_pt2 = 1; px2 = W - 1; py2 = H - 1;
    run_frame(1, 0);

    // R1 R2 R3: single pixel with junk outside qualifiers; old box discarded
    use_pt = 1; px = 9; py = 4; use_pt2 = 0;
    run_frame(0, 1);

    // R8: empty frame with junk, result held
    use_pt = 0;
    run_frame(0, 1);

    // R2 R6: wide flat rectangle and a separate point, odd sums
    use_rect = 1; rx0 = 10; ry0 = 6; rx1 = 13; ry1 = 6; use_pt = 1; px = 1; py = 9;
    run_frame(1, 1);

    repeat (4) @(negedge clk);
    // R7: one strobe per frame, nothing left in the scoreboard
    check("R7", "strobe count", n_strobes, n_frames);
    check("R7", "pending results", q.size(), 0);
    finish_run();
  end

endmodule